// File: doc/BRIEF.md
# Strided Block DMA Engine

This engine copies bytes between a banked local scratch memory (an instruction bank and a data bank, each 4 KiB) and a larger byte-addressed external memory. Software first sets a local address register and an external address register. It then writes a length word to one of two start offsets. Writing to offset 0x08 copies from external memory into local memory. Writing to offset 0x0C copies from local memory out to external memory. A transfer is two-dimensional. Each row has a fixed byte size. On the external side, a programmable gap follows every row except the last.

The length word carries three fields. The row size sits in bits 11:0. The number of rows minus one sits in bits 19:12. The external gap between rows sits in bits 31:20. When the copy finishes, the engine records the final local address with its bank and the final external address. Software reads these from the address offsets. The length word is also rewritten to a fixed completion pattern.

The external port moves one byte per cycle with a valid/ready handshake. The local memory port reads combinationally. The control is a four-state machine:
- IDLE waits for an accepted start write and then goes to MOVE.
- MOVE transfers one byte on each accepted handshake. After the last byte of a row it goes to STEP.
- STEP advances both row bases. It goes back to MOVE while rows remain, and otherwise to DONE.
- DONE latches the final addresses and the completion length, then returns to IDLE.

Top module: `sdma_top`

## Requirements
- R1: After reset, offsets 0x00, 0x04 and 0x08 read 0, `busy` is 0 and `ext_valid` is 0.
- R2: Each row moves (row field + 1) bytes, rounded up to the next multiple of 8. For example, a row field of 0 gives 8 bytes and a row field of 9 gives 16 bytes.
- R3: The number of rows moved is the row-count field + 1.
- R4: After each row except the last, the external address advances by the row size plus the gap field. After the last row it advances by the row size only.
- R5: The local address is kept as bits 11:3 and wraps within its 4 KiB bank. It advances by the row size only. Bit 12 of the local address register selects the bank: 1 selects the instruction bank and 0 selects the data bank. This is driven on `loc_bank`.
- R6: The external address is kept as bits 23:3 and wraps within a 24-bit space. Bits 2:0 of the programmed external address are dropped.
- R7: A start at offset 0x08 reads external memory (`ext_we`=0) and writes each byte, unchanged, to local memory. A start at offset 0x0C reads local memory and writes each byte, unchanged, to external memory (`ext_we`=1), with no local write.
- R8: When a transfer completes, offsets 0x08 and 0x0C read back the gap field in bits 31:20, zero in bits 19:12 and 0xFF8 in bits 11:0.
- R9: When a transfer completes, offset 0x00 reads the final local address in bits 11:0 with its bank in bit 12, and offset 0x04 reads the final external address.
- R10: `busy` rises only after an accepted start write and stays high until the transfer finishes. A start write that arrives while `busy` is high is ignored and does not change the transfer or its results.
- R11: A byte moves only on a cycle where `ext_valid` and `ext_ready` are both high. While `ext_ready` is low, the engine holds `ext_valid`, `ext_addr` and `ext_we` steady and does not write local memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| busy | output | 1 | Transfer in progress |
| ext_valid | output | 1 | External byte request |
| ext_we | output | 1 | External request is a write |
| ext_addr | output | 24 | External byte address |
| ext_wdata | output | 8 | External write byte |
| ext_ready | input | 1 | External memory accepts the byte this cycle |
| ext_rdata | input | 8 | External read byte, valid while ext_ready is high |
| loc_we | output | 1 | Local memory write strobe |
| loc_bank | output | 1 | Local bank select (1 = instruction bank) |
| loc_addr | output | 12 | Local byte address within the bank |
| loc_wdata | output | 8 | Local write byte |
| loc_rdata | input | 8 | Local read byte (combinational) |

## Verification
The bench targets several corner cases, each paired with the fault it would expose:
- **Row rounding.** Rows whose size is not a multiple of 8 are tested. A design that skips the rounding issues too few bytes and ends on the wrong addresses.
- **Gap after the last row.** The bench checks the final external address. A design that adds the gap after the last row reports an address that is too high by exactly the gap.
- **Wrap-around.** Transfers start near the top of a local bank and near the top of the external space. A design that carries into the bank bit or past 24 bits places bytes outside the bank or the external space.
- **Stalls and a start while busy.** Random stalls on `ext_ready`, together with a second start write during a busy transfer, catch a design that skips or repeats bytes under back-pressure, or that restarts on the ignored write.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MOVE = 2'd1,
        ST_STEP = 2'd2,
        ST_DONE = 2'd3
    } sdma_state_t;

    localparam logic [4:0] OFS_LOC = 5'h00;
    localparam logic [4:0] OFS_EXT = 5'h04;
    localparam logic [4:0] OFS_IN  = 5'h08;
    localparam logic [4:0] OFS_OUT = 5'h0C;

endpackage

// File: rtl/sdma_regs.sv
module sdma_regs
    import sdma_pkg::*;
#(
    parameter int LOC_AW = 12,
    parameter int EXT_AW = 24,
    parameter int LEN_W  = 12,
    parameter int CNT_W  = 8,
    parameter int RA_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic [LOC_AW-1:0] fin_loc,
    input  logic              fin_bank,
    input  logic [EXT_AW-1:0] fin_ext,
    output logic [LOC_AW-1:0] prog_loc,
    output logic              prog_bank,
    output logic [EXT_AW-1:0] prog_ext,
    output logic              start,
    output logic              start_out
);

    localparam int GAP_LSB = LEN_W + CNT_W;
    localparam logic [LEN_W-1:0] FIN_LEN = {{(LEN_W-3){1'b1}}, 3'b000};

    logic              hit_loc, hit_ext, hit_in, hit_out;
    logic [31:0]       len_q;
    logic [LOC_AW-1:0] last_loc;
    logic              last_bank;
    logic [EXT_AW-1:0] last_ext;

    assign hit_loc   = (reg_addr == RA_W'(OFS_LOC));
    assign hit_ext   = (reg_addr == RA_W'(OFS_EXT));
    assign hit_in    = (reg_addr == RA_W'(OFS_IN));
    assign hit_out   = (reg_addr == RA_W'(OFS_OUT));
    assign start     = reg_wr && !busy && (hit_in || hit_out);
    assign start_out = hit_out;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_loc  <= '0;
            prog_bank <= 1'b0;
            prog_ext  <= '0;
        end else if (reg_wr) begin
            if (hit_loc) begin
                prog_loc  <= {reg_wdata[LOC_AW-1:3], 3'b000};
                prog_bank <= reg_wdata[LOC_AW];
            end
            if (hit_ext) begin
                prog_ext <= {reg_wdata[EXT_AW-1:3], 3'b000};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q     <= '0;
            last_loc  <= '0;
            last_bank <= 1'b0;
            last_ext  <= '0;
        end else if (start) begin
            len_q <= reg_wdata;
        end else if (done) begin
            len_q     <= {len_q[31:GAP_LSB], {CNT_W{1'b0}}, FIN_LEN};
            last_loc  <= fin_loc;
            last_bank <= fin_bank;
            last_ext  <= fin_ext;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (hit_loc)               reg_rdata = 32'({last_bank, last_loc});
        else if (hit_ext)          reg_rdata = 32'(last_ext);
        else if (hit_in || hit_out) reg_rdata = len_q;
    end

endmodule

// File: rtl/sdma_seq.sv
module sdma_seq
    import sdma_pkg::*;
#(
    parameter int LOC_AW = 12,
    parameter int EXT_AW = 24,
    parameter int LEN_W  = 12,
    parameter int CNT_W  = 8,
    parameter int GAP_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_out,
    input  logic [LEN_W-1:0]  len_f,
    input  logic [CNT_W-1:0]  cnt_f,
    input  logic [GAP_W-1:0]  gap_f,
    input  logic [LOC_AW-1:0] prog_loc,
    input  logic              prog_bank,
    input  logic [EXT_AW-1:0] prog_ext,
    output logic              busy,
    output logic              done,
    output logic [LOC_AW-1:0] fin_loc,
    output logic              fin_bank,
    output logic [EXT_AW-1:0] fin_ext,
    output logic              ext_valid,
    output logic              ext_we,
    output logic [EXT_AW-1:0] ext_addr,
    output logic [7:0]        ext_wdata,
    input  logic              ext_ready,
    input  logic [7:0]        ext_rdata,
    output logic              loc_we,
    output logic              loc_bank,
    output logic [LOC_AW-1:0] loc_addr,
    output logic [7:0]        loc_wdata,
    input  logic [7:0]        loc_rdata
);

    localparam int RL_W = LEN_W + 1;

    sdma_state_t       state_q, state_d;
    logic              out_q;
    logic [RL_W-1:0]   row_len, byte_idx, rl_sum;
    logic [CNT_W-1:0]  rows_left;
    logic [GAP_W-1:0]  gap_q;
    logic [LOC_AW-1:0] loc_base;
    logic              bank_q;
    logic [EXT_AW-1:0] ext_base, ext_sum;
    logic              last_byte, last_row;

    assign rl_sum    = {1'b0, len_f} + RL_W'(8);
    assign last_byte = (byte_idx == row_len - RL_W'(1));
    assign last_row  = (rows_left == '0);
    assign ext_sum   = ext_base + EXT_AW'(row_len) + (last_row ? '0 : EXT_AW'(gap_q));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_MOVE;
            ST_MOVE: if (ext_ready && last_byte) state_d = ST_STEP;
            ST_STEP: state_d = last_row ? ST_DONE : ST_MOVE;
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q     <= 1'b0;
            row_len   <= '0;
            byte_idx  <= '0;
            rows_left <= '0;
            gap_q     <= '0;
            loc_base  <= '0;
            bank_q    <= 1'b0;
            ext_base  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    out_q     <= start_out;
                    row_len   <= {rl_sum[RL_W-1:3], 3'b000};
                    byte_idx  <= '0;
                    rows_left <= cnt_f;
                    gap_q     <= gap_f;
                    loc_base  <= prog_loc;
                    bank_q    <= prog_bank;
                    ext_base  <= prog_ext;
                end
                ST_MOVE: if (ext_ready) begin
                    byte_idx <= last_byte ? '0 : byte_idx + RL_W'(1);
                end
                ST_STEP: begin
                    loc_base <= loc_base + LOC_AW'(row_len);
                    ext_base <= {ext_sum[EXT_AW-1:3], 3'b000};
                    if (!last_row) rows_left <= rows_left - CNT_W'(1);
                end
                ST_DONE: ;
            endcase
        end
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_DONE);
        ext_valid = (state_q == ST_MOVE);
        ext_we    = out_q;
        ext_addr  = ext_base + EXT_AW'(byte_idx);
        ext_wdata = loc_rdata;
        loc_we    = (state_q == ST_MOVE) && !out_q && ext_ready;
        loc_bank  = bank_q;
        loc_addr  = loc_base + LOC_AW'(byte_idx);
        loc_wdata = ext_rdata;
        fin_loc   = loc_base;
        fin_bank  = bank_q;
        fin_ext   = ext_base;
    end

endmodule

// File: rtl/sdma_top.sv
module sdma_top
    import sdma_pkg::*;
#(
    parameter int LOC_AW = 12,
    parameter int EXT_AW = 24,
    parameter int LEN_W  = 12,
    parameter int CNT_W  = 8,
    parameter int RA_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              busy,
    output logic              ext_valid,
    output logic              ext_we,
    output logic [EXT_AW-1:0] ext_addr,
    output logic [7:0]        ext_wdata,
    input  logic              ext_ready,
    input  logic [7:0]        ext_rdata,
    output logic              loc_we,
    output logic              loc_bank,
    output logic [LOC_AW-1:0] loc_addr,
    output logic [7:0]        loc_wdata,
    input  logic [7:0]        loc_rdata
);

    localparam int GAP_W   = 32 - LEN_W - CNT_W;
    localparam int GAP_LSB = LEN_W + CNT_W;

    logic              start, start_out, done, fin_bank, prog_bank;
    logic [LOC_AW-1:0] fin_loc, prog_loc;
    logic [EXT_AW-1:0] fin_ext, prog_ext;

    sdma_regs #(
        .LOC_AW(LOC_AW), .EXT_AW(EXT_AW), .LEN_W(LEN_W), .CNT_W(CNT_W), .RA_W(RA_W)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .done(done),
        .fin_loc(fin_loc), .fin_bank(fin_bank), .fin_ext(fin_ext),
        .prog_loc(prog_loc), .prog_bank(prog_bank), .prog_ext(prog_ext),
        .start(start), .start_out(start_out)
    );

    sdma_seq #(
        .LOC_AW(LOC_AW), .EXT_AW(EXT_AW), .LEN_W(LEN_W), .CNT_W(CNT_W), .GAP_W(GAP_W)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_out(start_out),
        .len_f(reg_wdata[LEN_W-1:0]), .cnt_f(reg_wdata[GAP_LSB-1:LEN_W]),
        .gap_f(reg_wdata[31:GAP_LSB]),
        .prog_loc(prog_loc), .prog_bank(prog_bank), .prog_ext(prog_ext),
        .busy(busy), .done(done), .fin_loc(fin_loc), .fin_bank(fin_bank), .fin_ext(fin_ext),
        .ext_valid(ext_valid), .ext_we(ext_we), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
        .ext_ready(ext_ready), .ext_rdata(ext_rdata),
        .loc_we(loc_we), .loc_bank(loc_bank), .loc_addr(loc_addr),
        .loc_wdata(loc_wdata), .loc_rdata(loc_rdata)
    );

endmodule

// File: rtl/sdma_chk.sv
module sdma_chk
    import sdma_pkg::*;
#(
    parameter int EXT_AW = 24,
    parameter int RA_W   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [RA_W-1:0]   reg_addr,
    input logic              busy,
    input logic              ext_valid,
    input logic              ext_ready,
    input logic              ext_we,
    input logic [EXT_AW-1:0] ext_addr,
    input logic              loc_we
);

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_valid && !ext_ready) |=> (ext_valid && $stable(ext_addr) && $stable(ext_we)));

    // R10
    valid_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_valid |-> busy);

    // R10
    busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_wr && (reg_addr == RA_W'(OFS_IN) || reg_addr == RA_W'(OFS_OUT))));

    // R7
    loc_write_inbound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loc_we |-> (ext_valid && ext_ready && !ext_we));

endmodule

bind sdma_top sdma_chk #(.EXT_AW(EXT_AW), .RA_W(RA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .busy(busy),
    .ext_valid(ext_valid), .ext_ready(ext_ready), .ext_we(ext_we),
    .ext_addr(ext_addr), .loc_we(loc_we)
);

// File: tb/sdma_top_tb_top.sv
`timescale 1ns/1ps
module sdma_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        busy, ext_valid, ext_we, ext_ready, loc_we, loc_bank;
    logic [23:0] ext_addr;
    logic [7:0]  ext_wdata, ext_rdata, loc_wdata, loc_rdata;
    logic [11:0] loc_addr;
    bit          stall_en = 1'b0;

    int errs = 0;
    int checks = 0;

    int q_ext[$];
    int q_loc[$];
    bit q_bank[$];
    bit cur_out;
    int exp_fin_loc, exp_fin_ext;
    logic [31:0] exp_len;

    always #4 clk = ~clk;

    function automatic logic [7:0] ext_pat(int a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] loc_pat(bit b, int a);
        return a[7:0] ^ {a[11:8], b, 3'b101};
    endfunction

    assign ext_rdata = ext_pat(int'(ext_addr));
    assign loc_rdata = loc_pat(loc_bank, int'(loc_addr));

    sdma_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .ext_valid(ext_valid), .ext_we(ext_we), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_ready(ext_ready), .ext_rdata(ext_rdata),
        .loc_we(loc_we), .loc_bank(loc_bank), .loc_addr(loc_addr),
        .loc_wdata(loc_wdata), .loc_rdata(loc_rdata)
    );

    task automatic check_eq(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Reference model: builds the expected byte sequence and the final register values
    task automatic build_model(bit out_dir, logic [31:0] locw, logic [31:0] extw, logic [31:0] lenw);
        int row  = ((int'(lenw & 32'hFFF) + 1 + 7) / 8) * 8;
        int rows = int'((lenw >> 12) & 32'hFF) + 1;
        int gap  = int'((lenw >> 20) & 32'hFFF);
        int la   = int'(locw & 32'hFF8);
        bit bk   = locw[12];
        int ea   = int'(extw & 32'hFFFFF8);
        cur_out = out_dir;
        for (int r = 0; r < rows; r++) begin
            for (int j = 0; j < row; j++) begin
                q_ext.push_back((ea + j) & 'hFFFFFF);
                q_loc.push_back((la + j) & 'hFFF);
                q_bank.push_back(bk);
            end
            ea = (ea + row + ((r == rows - 1) ? 0 : gap)) & 'hFFFFF8;
            la = (la + row) & 'hFF8;
        end
        exp_fin_loc = la | (int'(bk) << 12);
        exp_fin_ext = ea;
        exp_len     = (32'(gap) << 20) | 32'hFF8;
    endtask

    task automatic monitor_step();
        if (ext_valid && ext_ready) begin
            if (q_ext.size() == 0) begin
                check_eq("R3 R10 unexpected byte moved", 1, 0);
            end else begin
                int ea = q_ext.pop_front();
                int la = q_loc.pop_front();
                bit bk = q_bank.pop_front();
                check_eq("R2 R4 R6 external address", ext_addr, ea);
                check_eq("R5 local address", loc_addr, la);
                check_eq("R5 bank select", loc_bank, bk);
                check_eq("R7 direction", ext_we, cur_out);
                if (cur_out) begin
                    check_eq("R7 outbound data", ext_wdata, loc_pat(bk, la));
                    check_eq("R7 no local write outbound", loc_we, 0);
                end else begin
                    check_eq("R7 local write strobe", loc_we, 1);
                    check_eq("R7 inbound data", loc_wdata, ext_pat(ea));
                end
            end
        end else begin
            check_eq("R11 no local write without handshake", loc_we, 0);
        end
        if (q_ext.size() != 0) check_eq("R10 busy during transfer", busy, 1);
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) monitor_step();
        end
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        ext_ready = 1'b1;
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ext_ready = stall_en ? (lfsr[0] | lfsr[3]) : 1'b1;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    task automatic reg_write(logic [4:0] a, logic [31:0] d);
        @(posedge clk);
        #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
    endtask

    task automatic start_write(logic [4:0] a, logic [31:0] d, bit accepted,
                               logic [31:0] locw, logic [31:0] extw);
        @(posedge clk);
        #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        if (accepted) build_model(a == 5'h0C, locw, extw, d);
        #1;
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(logic [4:0] a, output logic [31:0] d);
        @(posedge clk);
        #1;
        reg_addr = a;
        #2;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while (busy && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check_eq("R10 transfer finishes", busy, 0);
    endtask

    task automatic check_results(string what);
        logic [31:0] d;
        check_eq({"R3 all rows moved ", what}, q_ext.size(), 0);
        reg_read(5'h00, d);
        check_eq({"R5 R9 final local address ", what}, d, exp_fin_loc);
        reg_read(5'h04, d);
        check_eq({"R4 R6 R9 final external address ", what}, d, exp_fin_ext);
        reg_read(5'h08, d);
        check_eq({"R8 length after done ", what}, d, exp_len);
        reg_read(5'h0C, d);
        check_eq({"R8 length at 0x0C ", what}, d, exp_len);
    endtask

    task automatic run_xfer(string what, bit out_dir, logic [31:0] locw,
                            logic [31:0] extw, logic [31:0] lenw);
        reg_write(5'h00, locw);
        reg_write(5'h04, extw);
        start_write(out_dir ? 5'h0C : 5'h08, lenw, 1'b1, locw, extw);
        wait_idle();
        check_results(what);
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        reg_read(5'h00, d); check_eq("R1 local address reset", d, 0);
        reg_read(5'h04, d); check_eq("R1 external address reset", d, 0);
        reg_read(5'h08, d); check_eq("R1 length reset", d, 0);
        check_eq("R1 busy reset", busy, 0);
        check_eq("R1 valid reset", ext_valid, 0);

        // R7 inbound, data bank, gap between three rows (R3 R4)
        run_xfer("inbound", 1'b0, 32'h0000_0100, 32'h0000_2000, {12'h008, 8'h02, 12'h00F});

        // R7 outbound, instruction bank, misaligned external address (R6), stalls (R11)
        stall_en = 1'b1;
        run_xfer("outbound", 1'b1, 32'h0000_1040, 32'h0000_3005, {12'h040, 8'h03, 12'h000});

        // R2 row field 9 rounds to 16; single row adds no gap (R4)
        run_xfer("round", 1'b0, 32'h0000_0208, 32'h0001_0000, {12'h100, 8'h00, 12'h009});

        // R5 local wrap inside bank
        run_xfer("local wrap", 1'b0, 32'h0000_1FF0, 32'h0000_4000, {12'h000, 8'h01, 12'h00F});

        // R6 external wrap at top of 24-bit space
        run_xfer("external wrap", 1'b1, 32'h0000_0080, 32'h00FF_FFF8, {12'h000, 8'h01, 12'h007});

        // R5 bits above the bank bit are dropped
        run_xfer("masking", 1'b1, 32'hFFFF_E0A7, 32'hFF12_3456, {12'h010, 8'h01, 12'h003});

        // R10 start while busy is ignored
        reg_write(5'h00, 32'h0000_0300);
        reg_write(5'h04, 32'h0000_5000);
        start_write(5'h0C, {12'h010, 8'h03, 12'h01F}, 1'b1, 32'h0000_0300, 32'h0000_5000);
        repeat (5) @(negedge clk);
        check_eq("R10 busy mid transfer", busy, 1);
        start_write(5'h08, {12'h7F0, 8'h07, 12'h0FF}, 1'b0, 32'h0, 32'h0);
        wait_idle();
        check_results("ignored start");

        stall_en = 1'b0;
        repeat (4) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule